// File: doc/BRIEF.md
# Serial-In Latched Output Register

This block turns a serial bit stream into eight channel-enable outputs for a bank of output drivers. Bits enter one at a time on the rising clock edge and move stage by stage along an eight-stage shift path. A strobe level copies the shift path into a bank of output latches, and the latches drive the channels. While the strobe is high the latches are transparent, so the channels follow the shift path as it moves.

Two controls turn every channel off at once: an output-disable input and an undervoltage lockout input. Both leave the stored bits alone. The protection logic supplies a per-channel fault mask that turns off only the channels it marks.

The last shift stage leaves the block as a serial output, so several blocks can be chained into one longer register. A clear input does not reset anything directly. Instead it replaces the incoming bit with zero, so clearing the channels takes clocks followed by a strobe.

Top module: `serial_latch_driver`

## Requirements
- R1: A synchronous active-high `rst` sets every shift stage and every latch to 0. After reset `chan_on` is 0 and `ser_out` is 0, even with `strobe` high.
- R2: On each rising `clk` edge, stage 0 takes `ser_in` and each stage k (k = 1..7) takes the previous value of stage k-1.
- R3: While `clr` is high, a 0 enters stage 0 in place of `ser_in`, and shifting continues as normal.
- R4: `ser_out` always equals stage 7, the last stage. The first bit shifted in appears there after eight clocks.
- R5: While `strobe` is high the latches are transparent. Each `chan_on[i]` then follows stage i in the same cycle the stage changes, provided no disable and no fault applies.
- R6: While `strobe` is low the latches hold the value they had when `strobe` fell, whatever shifting happens.
- R7: While `out_dis` is high all `chan_on` bits are 0. When `out_dis` returns low, the outputs show the latch contents unchanged.
- R8: A high `uv_lock` has exactly the effect of a high `out_dis`, including keeping the stored contents.
- R9: When `fault_mask[i]` is high, `chan_on[i]` is 0 whatever its latch bit is. The other channels are unaffected.
- R10: Two blocks chained (`ser_out` of the first feeding `ser_in` of the second) act as one 16-stage register. After 16 clocks the first 8 bits sent sit in the second block's latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data into stage 0 |
| clr | input | 1 | Feed zeros instead of `ser_in` while high |
| strobe | input | 1 | Latches transparent while high, holding while low |
| out_dis | input | 1 | Forces all channels off while high |
| uv_lock | input | 1 | Undervoltage indication, same effect as `out_dis` |
| fault_mask | input | 8 | Per-channel forced-off mask from protection logic |
| chan_on | output | 8 | Channel enables, 1 = channel on |
| ser_out | output | 1 | Last shift stage, for chaining |

## Verification
The bench targets four corner cases.

- **Strobe falling.** A latch that captured the shift path one edge too early would lose the last shifted bit when `strobe` falls. The bench checks the held value at that point.
- **Disable and restore.** `out_dis` and `uv_lock` are raised and then dropped. A design that cleared the latches instead of gating the outputs would come back dark.
- **Clear under a transparent strobe.** `clr` is held with `strobe` high. Zeros must walk through the channels one per clock, not all at once.
- **Sixteen-bit chain.** A 16-bit word is sent through two chained blocks. An off-by-one in the serial output tap would misplace every bit in the second block.

// File: rtl/slr_pkg.sv
package slr_pkg;

    // Control bundle shared by the submodules.
    typedef struct packed {
        logic clear;   // feed zero into stage 0
        logic strobe;  // latch transparency
        logic blank;   // all outputs forced off
    } slr_ctrl_t;

    // Bit entering the first stage.
    function automatic logic feed_bit(input logic din, input logic clear);
        return clear ? 1'b0 : din;
    endfunction

    // Global off condition: disable and undervoltage act the same.
    function automatic logic blank_all(input logic dis, input logic uv);
        return dis | uv;
    endfunction

endpackage

// File: rtl/slr_shift.sv
module slr_shift #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              din,
    input  slr_pkg::slr_ctrl_t ctrl,
    output logic [NUM_CH-1:0] stage_q,
    output logic [NUM_CH-1:0] stage_d
);
    localparam int LAST = NUM_CH - 1;

    assign stage_d = {stage_q[LAST-1:0], slr_pkg::feed_bit(din, ctrl.clear)};

    always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= stage_d;
    end

    assert_shift_move_R2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> stage_q[LAST:1] == $past(stage_q[LAST-1:0]));

    assert_clear_zero_R3: assert property (@(posedge clk) disable iff (rst)
        ctrl.clear |=> !stage_q[0]);

endmodule

// File: rtl/slr_latch.sv
module slr_latch #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  slr_pkg::slr_ctrl_t ctrl,
    input  logic [NUM_CH-1:0] stage_q,
    input  logic [NUM_CH-1:0] stage_d,
    output logic [NUM_CH-1:0] view
);
    logic [NUM_CH-1:0] held_q;

    // Capture the post-edge shift value so a falling strobe keeps what was shown.
    always_ff @(posedge clk) begin
        if (rst)              held_q <= '0;
        else if (ctrl.strobe) held_q <= stage_d;
    end

    assign view = ctrl.strobe ? stage_q : held_q;

    assert_latch_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.strobe && $past(!ctrl.strobe) && !$past(rst)) |-> view == $past(view));

endmodule

// File: rtl/slr_gate.sv
module slr_gate #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  slr_pkg::slr_ctrl_t ctrl,
    input  logic [NUM_CH-1:0] fault_mask,
    input  logic [NUM_CH-1:0] view,
    output logic [NUM_CH-1:0] chan_on
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign chan_on[i] = view[i] & ~fault_mask[i] & ~ctrl.blank;
    end

    assert_blank_off_R7: assert property (@(posedge clk) disable iff (rst)
        ctrl.blank |-> chan_on == '0);

    assert_fault_off_R9: assert property (@(posedge clk) disable iff (rst)
        (chan_on & fault_mask) == '0);

endmodule

// File: rtl/serial_latch_driver.sv
module serial_latch_driver #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_in,
    input  logic              clr,
    input  logic              strobe,
    input  logic              out_dis,
    input  logic              uv_lock,
    input  logic [NUM_CH-1:0] fault_mask,
    output logic [NUM_CH-1:0] chan_on,
    output logic              ser_out
);
    localparam int LAST = NUM_CH - 1;

    slr_pkg::slr_ctrl_t ctrl;
    logic [NUM_CH-1:0]  stage_q;
    logic [NUM_CH-1:0]  stage_d;
    logic [NUM_CH-1:0]  view;

    assign ctrl.clear  = clr;
    assign ctrl.strobe = strobe;
    assign ctrl.blank  = slr_pkg::blank_all(out_dis, uv_lock);

    slr_shift #(.NUM_CH(NUM_CH)) u_shift (
        .clk(clk), .rst(rst), .din(ser_in), .ctrl(ctrl),
        .stage_q(stage_q), .stage_d(stage_d)
    );

    slr_latch #(.NUM_CH(NUM_CH)) u_latch (
        .clk(clk), .rst(rst), .ctrl(ctrl),
        .stage_q(stage_q), .stage_d(stage_d), .view(view)
    );

    slr_gate #(.NUM_CH(NUM_CH)) u_gate (
        .clk(clk), .rst(rst), .ctrl(ctrl), .fault_mask(fault_mask),
        .view(view), .chan_on(chan_on)
    );

    assign ser_out = stage_q[LAST];

    assert_transparent_R5: assert property (@(posedge clk) disable iff (rst)
        (strobe && !out_dis && !uv_lock && fault_mask == '0) |-> chan_on == stage_q);

    assert_uv_blank_R8: assert property (@(posedge clk) disable iff (rst)
        uv_lock |-> chan_on == '0);

endmodule

// File: tb/tb_serial_latch_driver.sv
module tb_serial_latch_driver;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst, ser_in, clr, strobe, out_dis, uv_lock;
    logic [N-1:0] fault_mask;
    logic [N-1:0] chan_a, chan_b;
    logic ser_a, ser_b;

    always #5 clk = ~clk;

    serial_latch_driver #(.NUM_CH(N)) dut (
        .clk(clk), .rst(rst), .ser_in(ser_in), .clr(clr), .strobe(strobe),
        .out_dis(out_dis), .uv_lock(uv_lock), .fault_mask(fault_mask),
        .chan_on(chan_a), .ser_out(ser_a)
    );

    serial_latch_driver #(.NUM_CH(N)) dut2 (
        .clk(clk), .rst(rst), .ser_in(ser_a), .clr(clr), .strobe(strobe),
        .out_dis(out_dis), .uv_lock(uv_lock), .fault_mask('0),
        .chan_on(chan_b), .ser_out(ser_b)
    );

    typedef struct {
        logic [N-1:0] ca, cb;
        logic         sa, sb;
        string        tag;
    } exp_t;

    exp_t q[$];
    int   errors = 0;
    int   checks = 0;
    bit   done   = 0;

    // Reference state.
    logic [N-1:0] m_sa = '0, m_sb = '0, m_la = '0, m_lb = '0;

    task automatic step(input logic r, input logic d, input logic c, input logic s,
                        input logic dis, input logic uv, input logic [N-1:0] fm,
                        input string tag);
        exp_t e;
        logic [N-1:0] na, nb;
        @(negedge clk);
        rst = r; ser_in = d; clr = c; strobe = s; out_dis = dis; uv_lock = uv;
        fault_mask = fm;
        if (r) begin
            na = '0; nb = '0; m_la = '0; m_lb = '0;
        end else begin
            na = {m_sa[N-2:0], c ? 1'b0 : d};
            nb = {m_sb[N-2:0], c ? 1'b0 : m_sa[N-1]};
            if (s) begin m_la = na; m_lb = nb; end
        end
        m_sa = na; m_sb = nb;
        e.ca  = (dis | uv) ? '0 : (m_la & ~fm);
        e.cb  = (dis | uv) ? '0 : m_lb;
        e.sa  = m_sa[N-1];
        e.sb  = m_sb[N-1];
        e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare after every edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (chan_a !== e.ca || chan_b !== e.cb || ser_a !== e.sa || ser_b !== e.sb) begin
                    errors++;
                    $display("FAIL %s: act a=%h b=%h so=%b%b exp a=%h b=%h so=%b%b",
                             e.tag, chan_a, chan_b, ser_a, ser_b, e.ca, e.cb, e.sa, e.sb);
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0]  pat;
        logic [15:0] word;
        rst = 1; ser_in = 0; clr = 0; strobe = 1; out_dis = 0; uv_lock = 0; fault_mask = '0;
        // R1: reset with strobe high
        step(1, 1, 0, 1, 0, 0, '0, "R1 reset");
        step(1, 1, 0, 1, 0, 0, '0, "R1 reset");
        // R2/R6: shift a pattern with strobe low; channels stay dark
        pat = 8'hA5;
        for (int i = 7; i >= 0; i--) step(0, pat[i], 0, 0, 0, 0, '0, "R2 R6 shift hold");
        // R4: first bit now on ser_out; strobe pulse loads
        step(0, 0, 0, 1, 0, 0, '0, "R4 R5 strobe load");
        // R6: strobe low, keep shifting, latch holds
        for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, 0, '0, "R6 hold while shifting");
        // R5: transparent shifting
        for (int i = 0; i < 5; i++) step(0, i[0], 0, 1, 0, 0, '0, "R5 transparent");
        // R6: strobe falls; last shown value held
        step(0, 1, 0, 0, 0, 0, '0, "R6 strobe fall");
        step(0, 0, 0, 0, 0, 0, '0, "R6 strobe fall");
        // R7: disable, then restore
        step(0, 1, 0, 0, 1, 0, '0, "R7 disable");
        step(0, 1, 0, 0, 1, 0, '0, "R7 disable");
        step(0, 0, 0, 0, 0, 0, '0, "R7 restore");
        // R8: undervoltage
        step(0, 0, 0, 0, 0, 1, '0, "R8 undervoltage");
        step(0, 0, 0, 0, 0, 0, '0, "R8 restore");
        // R9: fault mask per channel
        step(0, 1, 0, 1, 0, 0, 8'hFF, "R9 all faulted");
        step(0, 1, 0, 1, 0, 0, 8'h0F, "R9 low half faulted");
        step(0, 1, 0, 1, 0, 0, 8'h81, "R9 edge channels faulted");
        // R3: clear walks zeros in under a transparent strobe
        for (int i = 0; i < 9; i++) step(0, 1, 1, 1, 0, 0, '0, "R3 clear");
        // R10: 16-bit chain
        word = 16'hC3A6;
        for (int i = 15; i >= 0; i--) step(0, word[i], 0, 0, 0, 0, '0, "R10 R4 chain shift");
        step(0, 0, 0, 1, 0, 0, '0, "R10 chain strobe");
        step(0, 0, 0, 0, 0, 0, '0, "R10 chain hold");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule